// File: doc/BRIEF.md
# DMA Completion Interrupt Control

This block keeps the interrupt bookkeeping for two banks of DMA channels. Each bank has one 32-bit control word. The word holds a latched completion flag for each of seven subchannels, a mask bit for each subchannel, a bank enable bit and a master flag. When a DMA engine reports that a channel has finished, the block records the completion in the right bank. It then decides whether the interrupt controller should be signalled and recomputes that bank's master flag.

A completion is reported as a single-cycle `done_valid` pulse with a 4-bit channel number. Bit 3 of the channel number picks the bank and bits 2:0 pick the subchannel. A completion is always accepted, so there is no back-pressure. Software reaches the words through a plain write port, where flag bits are cleared by writing ones, and through a combinational read port. For each accepted completion the block sends a one-hot stop strobe back to the channel logic, telling it to drop that channel's busy/start state and its end marker.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset both control words read as zero, and `irq_pulse` and `chan_stop` are low.
- R2: A write to bank `wr_sel` loads bits 31, 23 (bank enable), 22:16 (mask) and 15:0 from `wr_data`. The new value is readable from the cycle after the write edge.
- R3: In a write, each of bits 30:24 (completion flags) written as 1 clears that flag, and each written as 0 leaves it unchanged. A write never sets a flag.
- R4: An accepted completion on channel `c` sets flag bit 24+c[2:0] in bank c[3].
- R5: If, after an accepted completion, its bank has any flag bit whose matching mask bit (bit 16+n for flag 24+n) is set, `irq_pulse` is high for exactly the one cycle after that completion edge.
- R6: In the case of R5, bit 31 of the bank becomes a copy of the bank enable bit 23.
- R7: If, after an accepted completion, no flag of that bank has its mask bit set, bit 31 of the bank is cleared and no `irq_pulse` is produced.
- R8: Each accepted completion on channel `c` drives `chan_stop` with only bit `c` high, for the one cycle after the completion edge. `chan_stop` is otherwise zero.
- R9: A completion whose subchannel is 7 (channel 7 or 15) is ignored. It changes no word and gives no `irq_pulse` and no `chan_stop`.
- R10: When a write and a completion hit the same bank on the same edge, the write is applied first. The completion's flag is then set, and R5 to R7 use the written mask and enable.
- R11: `rd_data` always shows the current word of bank `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one control word |
| wr_sel | input | 1 | Bank selected by the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Bank shown on `rd_data` |
| rd_data | output | 32 | Current word of the selected bank |
| done_valid | input | 1 | Channel completion pulse |
| done_chan | input | 4 | Completed channel: bit 3 bank, bits 2:0 subchannel |
| irq_pulse | output | 1 | One-cycle interrupt request to the interrupt controller |
| chan_stop | output | 16 | One-hot strobe that clears the finished channel's busy state and end marker |

## Verification
Every result is due one edge after its stimulus. Word updates, `irq_pulse` and `chan_stop` all come from registers loaded on the edge that samples the write or completion, and `rd_data` is only a multiplexer after those registers. The bench drives its inputs 1 ns after a rising edge. It checks the outputs 1 ns after the next rising edge, setting `rd_sel` to each bank in turn within that same high phase, before it drives the next stimulus. Because a check is made every cycle, a pulse that stays high for a second cycle is caught as well as one that is missing.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Word layout: the positions are behaviour, since channel logic and software decode them
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LOW_LSB    = 0;
  localparam int unsigned LOW_W      = 16;
  localparam int unsigned MASK_LSB   = 16;
  localparam int unsigned ENABLE_BIT = 23;
  localparam int unsigned FLAG_LSB   = 24;
  localparam int unsigned MASTER_BIT = 31;
  localparam int unsigned FIELD_W    = 7;

  typedef struct packed {
    logic               master;
    logic [FIELD_W-1:0] flags;
    logic               enable;
    logic [FIELD_W-1:0] mask;
    logic [LOW_W-1:0]   low;
  } ctl_word_t;

  // Outcome of recording a completion in a word
  typedef struct packed {
    ctl_word_t word;
    logic      raise;
  } post_done_t;

  function automatic ctl_word_t apply_write(input ctl_word_t cur, input ctl_word_t wd);
    ctl_word_t nxt;
    nxt        = wd;
    nxt.flags  = cur.flags & ~wd.flags;
    return nxt;
  endfunction

  function automatic post_done_t apply_done(input ctl_word_t cur,
                                            input logic [FIELD_W-1:0] hit);
    post_done_t res;
    logic       any;
    res.word       = cur;
    res.word.flags = cur.flags | hit;
    any            = |(res.word.flags & res.word.mask);
    res.word.master = any & res.word.enable;
    res.raise      = any;
    return res;
  endfunction
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned NSUB  = 7,
  localparam int unsigned SUB_W  = $clog2(NSUB + 1),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned CH_W   = SUB_W + BANK_W,
  localparam int unsigned NSTOP  = NBANK * (1 << SUB_W)
) (
  input  logic              done_valid,
  input  logic [CH_W-1:0]   done_chan,
  output logic [NBANK-1:0]  bank_hit,
  output logic [NSUB-1:0]   sub_hit,
  output logic [NSTOP-1:0]  stop_vec
);
  logic [SUB_W-1:0]  sub_idx;
  logic [BANK_W-1:0] bank_idx;
  logic              accept;

  assign sub_idx  = done_chan[SUB_W-1:0];
  assign bank_idx = done_chan[CH_W-1:SUB_W];
  assign accept   = done_valid && (int'(sub_idx) < NSUB) && (int'(bank_idx) < NBANK);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b] = accept && (int'(bank_idx) == b);
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    assign sub_hit[s] = accept && (int'(sub_idx) == s);
  end

  for (genvar k = 0; k < NSTOP; k++) begin : g_stop
    assign stop_vec[k] = accept && (int'(done_chan) == k);
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              done_hit,
  input  logic [FIELD_W-1:0] done_sub,
  output logic [WORD_W-1:0] word_q,
  output logic              raise_q
);
  ctl_word_t  cur;
  ctl_word_t  after_wr;
  post_done_t after_done;
  ctl_word_t  nxt;
  logic       raise_d;

  assign cur = ctl_word_t'(word_q);

  always_comb begin
    after_wr   = wr_hit ? apply_write(cur, ctl_word_t'(wr_data)) : cur;
    after_done = apply_done(after_wr, done_sub);
    if (done_hit) begin
      nxt     = after_done.word;
      raise_d = after_done.raise;
    end else begin
      nxt     = after_wr;
      raise_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      raise_q <= 1'b0;
    end else begin
      word_q  <= WORD_W'(nxt);
      raise_q <= raise_d;
    end
  end
endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned NSTOP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] raise_q,
  input  logic [NSTOP-1:0] stop_d,
  output logic             irq_pulse,
  output logic [NSTOP-1:0] chan_stop
);
  // Bank raise flags are already registered; only one bank can raise per edge
  assign irq_pulse = |raise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_stop <= '0;
    else        chan_stop <= stop_d;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NBANK = 2,
  parameter int unsigned NSUB  = 7,
  localparam int unsigned SUB_W  = $clog2(NSUB + 1),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned CH_W   = SUB_W + BANK_W,
  localparam int unsigned NSTOP  = NBANK * (1 << SUB_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [BANK_W-1:0]  rd_sel,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               done_valid,
  input  logic [CH_W-1:0]    done_chan,
  output logic               irq_pulse,
  output logic [NSTOP-1:0]   chan_stop
);
  logic [NBANK-1:0]             bank_hit;
  logic [NSUB-1:0]              sub_hit;
  logic [NSTOP-1:0]             stop_vec;
  logic [FIELD_W-1:0]           sub_field;
  logic [NBANK-1:0]             raise_q;
  logic [NBANK-1:0][WORD_W-1:0] regs_q;

  dma_irq_decode #(.NBANK(NBANK), .NSUB(NSUB)) u_dec (
    .done_valid (done_valid),
    .done_chan  (done_chan),
    .bank_hit   (bank_hit),
    .sub_hit    (sub_hit),
    .stop_vec   (stop_vec)
  );

  assign sub_field = FIELD_W'(sub_hit);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr_hit_b;
    assign wr_hit_b = wr_en && (int'(wr_sel) == b);
    dma_irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit_b),
      .wr_data  (wr_data),
      .done_hit (bank_hit[b]),
      .done_sub (sub_field),
      .word_q   (regs_q[b]),
      .raise_q  (raise_q[b])
    );
  end

  assign rd_data = (int'(rd_sel) < NBANK) ? regs_q[rd_sel] : '0;

  dma_irq_out #(.NBANK(NBANK), .NSTOP(NSTOP)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_q   (raise_q),
    .stop_d    (stop_vec),
    .irq_pulse (irq_pulse),
    .chan_stop (chan_stop)
  );
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned NSUB  = 7,
  localparam int unsigned SUB_W  = $clog2(NSUB + 1),
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned CH_W   = SUB_W + BANK_W,
  localparam int unsigned NSTOP  = NBANK * (1 << SUB_W)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    done_valid,
  input logic [CH_W-1:0]         done_chan,
  input logic                    irq_pulse,
  input logic [NSTOP-1:0]        chan_stop,
  input logic [NBANK-1:0][31:0]  regs_q
);
  logic acc;
  assign acc = done_valid && (int'(done_chan[SUB_W-1:0]) < NSUB);

  // R4: accepted completion leaves its flag set
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> regs_q[$past(done_chan[CH_W-1:SUB_W])][24 + $past(done_chan[SUB_W-1:0])]);

  // R5: a request only follows an accepted completion
  a_r5_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(acc));

  // R8: stop strobe one-hot and only after an accepted completion
  a_r8_stop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_stop));
  a_r8_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_stop != '0) |-> $past(acc));

  // R9: ignored subchannel with no write changes nothing
  a_r9_sub7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !acc) |=> ($stable(regs_q) && !irq_pulse && chan_stop == '0));

  // R6/R7: master follows enable and qualified flags after a completion
  a_r6_master: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> regs_q[$past(done_chan[CH_W-1:SUB_W])][31] ==
            (regs_q[$past(done_chan[CH_W-1:SUB_W])][23] &&
             |(regs_q[$past(done_chan[CH_W-1:SUB_W])][30:24] &
               regs_q[$past(done_chan[CH_W-1:SUB_W])][22:16])));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NBANK(NBANK), .NSUB(NSUB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .done_valid (done_valid),
  .done_chan  (done_chan),
  .irq_pulse  (irq_pulse),
  .chan_stop  (chan_stop),
  .regs_q     (regs_q)
);

// File: tb/sim_dma_irq_ctrl.sv
`timescale 1ns/100ps
module sim_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        done_valid = 1'b0;
  logic [3:0]  done_chan = '0;
  logic        irq_pulse;
  logic [15:0] chan_stop;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [2];
  bit          done_flag = 0;

  always #2.5 clk = ~clk;

  dma_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .done_valid(done_valid), .done_chan(done_chan),
    .irq_pulse(irq_pulse), .chan_stop(chan_stop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Expected next word from the requirements (R2, R3, R4, R6, R7, R10)
  function automatic logic [31:0] next_word(input logic [31:0] cur, input bit wr,
      input logic [31:0] wd, input bit dn, input int sub, output bit raise);
    logic [31:0] w;
    w = cur;
    raise = 0;
    if (wr) begin
      w = wd;
      w[30:24] = cur[30:24] & ~wd[30:24];
    end
    if (dn) begin
      w[24 + sub] = 1'b1;
      raise = |(w[30:24] & w[22:16]);
      w[31] = raise & w[23];
    end
    return w;
  endfunction

  task automatic step(input bit we, input bit ws, input logic [31:0] wd,
                      input bit dv, input logic [3:0] ch, input string tag);
    bit r, acc, any_raise;
    logic [15:0] exp_stop;
    acc = dv && (ch[2:0] != 3'd7);
    any_raise = 0;
    for (int b = 0; b < 2; b++) begin
      mdl[b] = next_word(mdl[b], we && (ws == b), wd, acc && (ch[3] == b), int'(ch[2:0]), r);
      any_raise |= r;
    end
    exp_stop = acc ? (16'd1 << ch) : 16'd0;
    wr_en = we; wr_sel = ws; wr_data = wd; done_valid = dv; done_chan = ch;
    @(posedge clk);
    #1;
    wr_en = 0; done_valid = 0;
    check({tag, " R5/R7 irq_pulse"}, {31'd0, irq_pulse}, {31'd0, any_raise});
    check({tag, " R8 chan_stop"}, {16'd0, chan_stop}, {16'd0, exp_stop});
    rd_sel = 0; #0.2;
    check({tag, " R11 bank0"}, rd_data, mdl[0]);
    rd_sel = 1; #0.2;
    check({tag, " R11 bank1"}, rd_data, mdl[1]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mdl[0] = '0; mdl[1] = '0;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd_sel = 0; #0.2; check("R1 bank0", rd_data, 32'h0);
    rd_sel = 1; #0.2; check("R1 bank1", rd_data, 32'h0);
    check("R1 irq", {31'd0, irq_pulse}, 32'h0);
    check("R1 stop", {16'd0, chan_stop}, 32'h0);
    // R2/R3: all-ones write sets plain bits, flags stay clear
    step(1, 0, 32'hFFFF_FFFF, 0, 4'd0, "R2 R3 ones");
    // R4/R5/R6: completion on masked channel with enable -> master set
    step(0, 0, 0, 1, 4'd2, "R4 R6 ch2");
    // R3: clear flag 2 only
    step(1, 0, 32'h0480_0000, 0, 4'd0, "R3 w1c");
    // R7: bank1 mask zero -> no request, master cleared
    step(1, 1, 32'h8000_1234, 0, 4'd0, "R2 bank1");
    step(0, 0, 0, 1, 4'd9, "R7 ch9");
    // R9: subchannel 7 ignored on both banks
    step(0, 0, 0, 1, 4'd7, "R9 ch7");
    step(0, 0, 0, 1, 4'd15, "R9 ch15");
    // R10: same-cycle write and completion, enable off in written value
    step(1, 1, 32'h7F7F_0000, 1, 4'd14, "R10 same");
    step(1, 1, 32'h00FF_0000, 1, 4'd8, "R10 enable");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rw;
      rw = $urandom;
      step(($urandom % 3) == 0, $urandom % 2, rw, ($urandom % 2) == 1,
           4'($urandom % 16), "rand R2 R3 R4");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule